// File: doc/BRIEF.md
# Condition Register Bit-Logic Unit

This unit executes the single-bit logical operations and the four-bit field copy that work on a 32-bit condition register (CR). Each request gives an operation code, three 5-bit bit indices (`dst_bit`, `src_a_bit`, `src_b_bit`), two 3-bit field indices (`dst_fld`, `src_fld`) and the current CR value on `cr_in`. When `in_valid` is high, the updated CR is captured in an output register. It appears on `cr_out` one clock later, together with a one-cycle `out_valid` pulse.

A logical operation reads two single CR bits and combines them with one of eight two-input functions. It then writes the result into one destination bit. The field copy moves one 4-bit field onto another. Bits are numbered from the most significant end, so index 0 is the MSB of the register. Every CR bit outside the destination keeps its value from `cr_in`.

Top module: `crl_unit`

## Requirements
- R1: After a synchronous active-high reset, `cr_out` is 0 and `out_valid` is 0.
- R2: Bit index i selects vector position `cr[31-i]` (MSB-first numbering), and field index f selects `cr[31-4f : 28-4f]`.
- R3: Opcodes 0 AND, 1 NAND, 2 OR and 3 XOR write f(A,B) into the destination bit. A is the bit at `src_a_bit` and B is the bit at `src_b_bit`.
- R4: Opcodes 4 NOR, 5 XNOR (equivalence), 6 A AND NOT B and 7 A OR NOT B write their result into the destination bit.
- R5: Opcode 8 copies the 4-bit field at `src_fld` into the field at `dst_fld`.
- R6: Only the destination bit (opcodes 0–7) or the destination field (opcode 8) may differ from `cr_in`. All other bits are passed through unchanged.
- R7: When destination and source indices coincide, the result is computed from `cr_in` as it was before the write. A field copied onto itself leaves CR unchanged.
- R8: Opcodes 9 to 15 are reserved. A valid request with one of them yields `cr_out == cr_in` and still pulses `out_valid`.
- R9: A request accepted with `in_valid` high appears on `cr_out` at the next rising clock edge, with `out_valid` high for exactly that cycle.
- R10: While `in_valid` is low, `cr_out` holds its previous value regardless of `cr_in`, and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| dst_bit | input | 5 | Destination bit index (MSB = 0) |
| src_a_bit | input | 5 | First source bit index |
| src_b_bit | input | 5 | Second source bit index |
| dst_fld | input | 3 | Destination field index (field copy) |
| src_fld | input | 3 | Source field index (field copy) |
| cr_in | input | 32 | Current condition register value |
| cr_out | output | 32 | Registered updated condition register |
| out_valid | output | 1 | High for the cycle in which `cr_out` carries a new result |

## Verification
Every result, whether from a logical operation, the field copy or a reserved opcode, is due exactly one rising edge after the request is presented. The inputs are driven on a falling edge and the outputs are compared on the following falling edge. That places each comparison half a period after the capturing edge. The hold behaviour is checked by sampling again one and two falling edges after `in_valid` drops, with `cr_in` deliberately changed in between. This confirms that nothing moves and that `out_valid` stays low.

// File: rtl/crl_pkg.sv
package crl_pkg;

    localparam int CR_W      = 32;
    localparam int FIELD_W   = 4;
    localparam int N_FIELDS  = CR_W / FIELD_W;
    localparam int BIT_IDX_W = $clog2(CR_W);
    localparam int FLD_IDX_W = $clog2(N_FIELDS);
    localparam int OP_W      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_NAND = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_NOR  = 4'd4,
        OP_EQV  = 4'd5,
        OP_ANDC = 4'd6,
        OP_ORC  = 4'd7,
        OP_MOVE = 4'd8
    } crl_op_e;

    typedef enum logic [1:0] {
        SEL_BIT  = 2'd0,
        SEL_FLD  = 2'd1,
        SEL_PASS = 2'd2
    } crl_sel_e;

    typedef struct packed {
        logic [BIT_IDX_W-1:0] dst;
        logic [BIT_IDX_W-1:0] src_a;
        logic [BIT_IDX_W-1:0] src_b;
    } crl_bit_req_t;

    typedef struct packed {
        logic [FLD_IDX_W-1:0] dst;
        logic [FLD_IDX_W-1:0] src;
    } crl_fld_req_t;

    // Two-input boolean function selected by the low opcode bits.
    function automatic logic crl_eval(input logic [2:0] fn, input logic a, input logic b);
        logic r;
        case (fn)
            3'd0:    r = a & b;
            3'd1:    r = ~(a & b);
            3'd2:    r = a | b;
            3'd3:    r = a ^ b;
            3'd4:    r = ~(a | b);
            3'd5:    r = ~(a ^ b);
            3'd6:    r = a & ~b;
            default: r = a | ~b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/crl_decode.sv
module crl_decode
    import crl_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] op,
    output crl_sel_e       sel,
    output logic [2:0]     fn
);
    always_comb begin
        fn = op[2:0];
        if (op < OPW'(OP_MOVE))       sel = SEL_BIT;
        else if (op == OPW'(OP_MOVE)) sel = SEL_FLD;
        else                          sel = SEL_PASS;
    end
endmodule

// File: rtl/crl_bit_logic.sv
module crl_bit_logic
    import crl_pkg::*;
#(
    parameter int W  = CR_W,
    parameter int IW = BIT_IDX_W
) (
    input  logic [W-1:0]  cr,
    input  logic [2:0]    fn,
    input  logic [IW-1:0] dst,
    input  logic [IW-1:0] src_a,
    input  logic [IW-1:0] src_b,
    output logic [W-1:0]  cr_next
);
    localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask_a, mask_b, mask_d;
    logic         bit_a, bit_b, res;

    always_comb begin
        // MSB-first numbering: index 0 is the top bit
        mask_a  = TOP >> src_a;
        mask_b  = TOP >> src_b;
        mask_d  = TOP >> dst;
        bit_a   = |(cr & mask_a);
        bit_b   = |(cr & mask_b);
        res     = crl_eval(fn, bit_a, bit_b);
        cr_next = (cr & ~mask_d) | (res ? mask_d : '0);
    end
endmodule

// File: rtl/crl_field_move.sv
module crl_field_move
    import crl_pkg::*;
#(
    parameter int W  = CR_W,
    parameter int FW = FIELD_W,
    parameter int FI = FLD_IDX_W
) (
    input  logic [W-1:0]  cr,
    input  logic [FI-1:0] dst,
    input  logic [FI-1:0] src,
    output logic [W-1:0]  cr_next
);
    localparam int NF = W / FW;

    logic [FW-1:0] fields [NF];
    logic [FW-1:0] moved;

    for (genvar f = 0; f < NF; f++) begin : g_fld
        // field f occupies the f-th nibble counted from the MSB
        assign fields[f] = cr[W-1-f*FW -: FW];
        assign cr_next[W-1-f*FW -: FW] = (dst == FI'(f)) ? moved : fields[f];
    end

    assign moved = fields[src];
endmodule

// File: rtl/crl_unit.sv
module crl_unit
    import crl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      op,
    input  logic [BIT_IDX_W-1:0] dst_bit,
    input  logic [BIT_IDX_W-1:0] src_a_bit,
    input  logic [BIT_IDX_W-1:0] src_b_bit,
    input  logic [FLD_IDX_W-1:0] dst_fld,
    input  logic [FLD_IDX_W-1:0] src_fld,
    input  logic [CR_W-1:0]      cr_in,
    output logic [CR_W-1:0]      cr_out,
    output logic                 out_valid
);
    crl_bit_req_t breq;
    crl_fld_req_t freq;
    crl_sel_e     sel;
    logic [2:0]   fn;
    logic [CR_W-1:0] bit_res, fld_res, next_cr;

    assign breq = '{dst: dst_bit, src_a: src_a_bit, src_b: src_b_bit};
    assign freq = '{dst: dst_fld, src: src_fld};

    crl_decode #(.OPW(OP_W)) u_dec (.op(op), .sel(sel), .fn(fn));

    crl_bit_logic #(.W(CR_W), .IW(BIT_IDX_W)) u_bit (
        .cr(cr_in), .fn(fn), .dst(breq.dst), .src_a(breq.src_a),
        .src_b(breq.src_b), .cr_next(bit_res)
    );

    crl_field_move #(.W(CR_W), .FW(FIELD_W), .FI(FLD_IDX_W)) u_fld (
        .cr(cr_in), .dst(freq.dst), .src(freq.src), .cr_next(fld_res)
    );

    always_comb begin
        case (sel)
            SEL_BIT: next_cr = bit_res;
            SEL_FLD: next_cr = fld_res;
            default: next_cr = cr_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_out    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cr_out <= next_cr;
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(cr_out)));

    // R6
    one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op < OP_W'(OP_MOVE)) |=> ($countones(cr_out ^ $past(cr_in)) <= 1));

    // R5
    field_only_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_W'(OP_MOVE)) |=>
        (((cr_out ^ $past(cr_in)) &
          ~({{FIELD_W{1'b1}}, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * $past(dst_fld)))) == '0));

    // R8
    reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > OP_W'(OP_MOVE)) |=> (cr_out == $past(cr_in)));
endmodule

// File: tb/crl_unit_bench.sv
module crl_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [4:0]  dst_bit, src_a_bit, src_b_bit;
    logic [2:0]  dst_fld, src_fld;
    logic [31:0] cr_in;
    logic [31:0] cr_out;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    crl_unit u_crl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .dst_bit(dst_bit), .src_a_bit(src_a_bit), .src_b_bit(src_b_bit),
        .dst_fld(dst_fld), .src_fld(src_fld), .cr_in(cr_in),
        .cr_out(cr_out), .out_valid(out_valid)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  bt, ba, bb;
        logic [2:0]  bf, bfa;
        logic [31:0] cr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{4'd0, 5'd5,  5'd0,  5'd31, 3'd0, 3'd0, 32'h8000_0001, 32'h8400_0001}, // R3 AND
        '{4'd1, 5'd5,  5'd0,  5'd31, 3'd0, 3'd0, 32'h8400_0001, 32'h8000_0001}, // R3 NAND
        '{4'd2, 5'd0,  5'd3,  5'd4,  3'd0, 3'd0, 32'h0000_0000, 32'h0000_0000}, // R3 OR zero
        '{4'd2, 5'd31, 5'd3,  5'd4,  3'd0, 3'd0, 32'h1000_0000, 32'h1000_0001}, // R2 R3 OR
        '{4'd3, 5'd3,  5'd3,  5'd4,  3'd0, 3'd0, 32'h1800_0000, 32'h0800_0000}, // R7 XOR
        '{4'd4, 5'd1,  5'd1,  5'd2,  3'd0, 3'd0, 32'h0000_0000, 32'h4000_0000}, // R4 NOR
        '{4'd5, 5'd9,  5'd7,  5'd8,  3'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R4 EQV
        '{4'd5, 5'd9,  5'd7,  5'd8,  3'd0, 3'd0, 32'h0140_0000, 32'h0100_0000}, // R4 EQV
        '{4'd6, 5'd16, 5'd30, 5'd31, 3'd0, 3'd0, 32'h0000_0002, 32'h0000_8002}, // R4 ANDC
        '{4'd7, 5'd0,  5'd0,  5'd0,  3'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R7 ORC
        '{4'd7, 5'd20, 5'd10, 5'd31, 3'd0, 3'd0, 32'h0000_0801, 32'h0000_0001}, // R4 ORC
        '{4'd7, 5'd20, 5'd10, 5'd12, 3'd0, 3'd0, 32'h0000_0000, 32'h0000_0800}, // R4 ORC
        '{4'd8, 5'd0,  5'd0,  5'd0,  3'd7, 3'd0, 32'h1234_5678, 32'h1234_5671}, // R5 move
        '{4'd8, 5'd0,  5'd0,  5'd0,  3'd2, 3'd5, 32'h1234_5678, 32'h1264_5678}, // R5 R6 move
        '{4'd8, 5'd0,  5'd0,  5'd0,  3'd3, 3'd3, 32'h1234_5678, 32'h1234_5678}, // R7 self move
        '{4'd15,5'd0,  5'd0,  5'd0,  3'd1, 3'd2, 32'hA5A5_A5A5, 32'hA5A5_A5A5}, // R8 reserved
        '{4'd9, 5'd4,  5'd4,  5'd4,  3'd0, 3'd4, 32'h0F0F_0F0F, 32'h0F0F_0F0F}  // R8 reserved
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; dst_bit = v.bt; src_a_bit = v.ba; src_b_bit = v.bb;
        dst_fld = v.bf; src_fld = v.bfa; cr_in = v.cr; in_valid = 1'b1;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; dst_bit = '0; src_a_bit = '0;
        src_b_bit = '0; dst_fld = '0; src_fld = '0; cr_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cr_out", cr_out, 32'h0);
        check("R1 out_valid", {31'b0, out_valid}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            @(negedge clk);
            check($sformatf("R2-vector %0d result", i), cr_out, VT[i].exp);
            check("R9 out_valid", {31'b0, out_valid}, 32'h1);
            in_valid = 1'b0;
        end

        // R10: hold with changing cr_in
        @(negedge clk);
        drive('{4'd2, 5'd0, 5'd1, 5'd2, 3'd0, 3'd0, 32'h4000_0000, 32'h0});
        @(negedge clk);
        check("R9 OR result", cr_out, 32'hC000_0000);
        in_valid = 1'b0; cr_in = 32'h0000_FFFF; op = 4'd8;
        @(negedge clk);
        check("R10 hold cr_out", cr_out, 32'hC000_0000);
        check("R10 out_valid low", {31'b0, out_valid}, 32'h0);
        cr_in = 32'h1111_1111;
        @(negedge clk);
        check("R10 hold cr_out 2", cr_out, 32'hC000_0000);

        // R9 back-to-back requests
        drive('{4'd0, 5'd31, 5'd0, 5'd0, 3'd0, 3'd0, 32'h8000_0000, 32'h0});
        @(negedge clk);
        check("R9 b2b first", cr_out, 32'h8000_0001);
        check("R9 b2b valid1", {31'b0, out_valid}, 32'h1);
        drive('{4'd8, 5'd0, 5'd0, 5'd0, 3'd0, 3'd7, 32'h0000_000C, 32'h0});
        @(negedge clk);
        check("R5 b2b move", cr_out, 32'hC000_000C);
        check("R9 b2b valid2", {31'b0, out_valid}, 32'h1);
        in_valid = 1'b0;

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", cr_out, 32'h0);
        check("R1 valid again", {31'b0, out_valid}, 32'h0);
        rst = 1'b0;
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule